// File: doc/BRIEF.md
# HDLC Bit-Stream Frame Receiver

This block is the serial receive path for bit-oriented HDLC/SDLC links. It is clocked by the 1X receive clock and takes one line bit on every rising edge while carrier detect is high. A static mode input can select NRZI decoding. The decoded stream passes through a run-of-ones classifier, which recognises the 01111110 flag, removes the zero inserted after five ones, and spots abort and idle runs. A seven-bit look-ahead holds content bits back until they cannot belong to a closing flag. The bits that pass it are packed into octets, least significant bit first, and fed to a CRC-16 checker.

Each octet is delivered on `out_valid` with a start-of-frame marker on the first one. The final two octets of a frame are the frame check sequence and are never delivered. When the closing flag arrives, `frame_done` pulses once, with `frame_err` giving the verdict. A flag-detect pulse, an abort pulse and an idle-line level complete the outputs.

The output stream has no ready input, because a serial line cannot be paused. Any consumer must accept every cycle in which `out_valid` is high. Two valid octets are always at least eight cycles apart. All outputs are registered and change one clock after the line bit that causes them.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: Every 01111110 pattern received with carrier detect high gives a one-cycle `flag_det` pulse in the cycle after its last bit.
- R2: Between flags, a zero that follows five consecutive ones is removed. The remaining content is packed least significant bit first into octets on `out_data` with a one-cycle `out_valid`, and `out_sof` is high with the first octet of each frame only.
- R3: The two octets before the closing flag are withheld as FCS. The FCS is CRC-16 with polynomial x^16+x^12+x^5+1, processed bit-reflected (0x8408), preset 0xFFFF. The sender transmits the ones' complement of the register, low octet first, each octet LSB first. A frame whose register ends at 0xF0B8 gives `frame_done`=1 with `frame_err`=0 one cycle after the closing flag.
- R4: A frame whose CRC residue is not 0xF0B8 gives `frame_done`=1 with `frame_err`=1.
- R5: A frame with fewer than two content octets, or with a content bit count that is not a multiple of eight, gives `frame_done`=1 with `frame_err`=1.
- R6: With `nrzi_en`=1, a line level equal to the previously sampled level is decoded as a one, and a change of level is decoded as a zero. The reset reference level is high.
- R7: Cycles with `cd`=0 are ignored entirely: they do not advance decoding, ones counting or assembly, and no output pulse follows them.
- R8: Seven consecutive ones after at least one content octet give a one-cycle `abort_det` pulse. The frame is then dropped with no `frame_done`, and the next flag opens a new frame normally. Seven ones directly after a flag give no `abort_det`.
- R9: `line_idle` goes high after the fifteenth consecutive one and low after the next zero.
- R10: After reset, all outputs are low.
- R11: Adjacent flags with no content between them give no `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1X receive clock, one line bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| nrzi_en | input | 1 | 1 selects NRZI decoding of `rxd` |
| cd | input | 1 | Carrier detect; the line is sampled only while high |
| rxd | input | 1 | Serial receive data |
| out_valid | output | 1 | Delivered octet strobe (no back-pressure) |
| out_data | output | 8 | Delivered octet |
| out_sof | output | 1 | High with the first octet of a frame |
| frame_done | output | 1 | One-cycle pulse at the closing flag of a frame |
| frame_err | output | 1 | Valid with `frame_done`: FCS, length or alignment error |
| abort_det | output | 1 | One-cycle pulse on an abort inside a frame |
| flag_det | output | 1 | One-cycle pulse per recognised flag |
| line_idle | output | 1 | High while the line shows fifteen or more ones |

## Verification
The hardest situations to reach from the ports are those where stuffed zeros, carrier-detect gaps and NRZI level tracking all interact inside one frame. The FCS octets themselves often contain runs of five ones that need a deletion right next to the closing flag. Random payloads are therefore sent with randomly placed carrier-low cycles in both line codings, and a bench encoder stuffs and NRZI-encodes exactly as a transmitter would. Directed sequences cover the other cases: an abort after content, ones directly after a flag, the idle threshold (probed through carrier-low pauses so that the run is not extended), and frames that are short or misaligned.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int unsigned OCTET_W       = 8;
  localparam int unsigned FCS_W         = 16;
  localparam logic [FCS_W-1:0] FCS_POLY_REFL = 16'h8408;
  localparam logic [FCS_W-1:0] FCS_PRESET    = 16'hFFFF;
  localparam logic [FCS_W-1:0] FCS_RESIDUE   = 16'hF0B8;

  typedef enum logic {ST_HUNT = 1'b0, ST_OPEN = 1'b1} rx_state_e;
endpackage

// File: rtl/hdlc_rx_line.sv
module hdlc_rx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic nrzi_en,
  input  logic cd,
  input  logic rxd,
  output logic bit_vld,
  output logic bit_val
);
  logic last_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n)  last_lvl <= 1'b1;
    else if (cd) last_lvl <= rxd;
  end

  assign bit_vld = cd;
  assign bit_val = nrzi_en ? ~(rxd ^ last_lvl) : rxd;
endmodule

// File: rtl/hdlc_rx_delin.sv
module hdlc_rx_delin #(
  parameter int unsigned STUFF_RUN = 5,
  parameter int unsigned IDLE_RUN  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_val,
  output logic push,
  output logic push_bit,
  output logic flag_hit,
  output logic abort_hit,
  output logic line_idle
);
  localparam int unsigned FLAG_RUN = STUFF_RUN + 1;
  localparam int unsigned CW       = $clog2(IDLE_RUN + 1);

  logic [CW-1:0] ones;

  always_comb begin
    push      = 1'b0;
    push_bit  = bit_val;
    flag_hit  = 1'b0;
    abort_hit = 1'b0;
    if (bit_vld) begin
      if (bit_val) begin
        if (ones < CW'(FLAG_RUN))       push      = 1'b1;
        else if (ones == CW'(FLAG_RUN)) abort_hit = 1'b1;
      end else begin
        if (ones == CW'(FLAG_RUN))      flag_hit  = 1'b1;
        else if (ones < CW'(STUFF_RUN)) push      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones      <= '0;
      line_idle <= 1'b0;
    end else if (bit_vld) begin
      if (bit_val) begin
        if (ones != CW'(IDLE_RUN)) ones <= ones + 1'b1;
        if (ones == CW'(IDLE_RUN - 1)) line_idle <= 1'b1;
      end else begin
        ones      <= '0;
        line_idle <= 1'b0;
      end
    end
  end

  // R9: idle can only begin on a sampled one
  a_r9_idle_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_idle) |-> $past(bit_vld && bit_val));

  // R1: a flag and an abort never come from the same bit
  a_r1_flag_excl_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_hit && abort_hit) && !(flag_hit && push));
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
  import hdlc_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             din,
  output logic [FCS_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= FCS_PRESET;
    else if (upd)      crc <= (crc >> 1) ^ ((crc[0] ^ din) ? FCS_POLY_REFL : '0);
  end

  // R3: every frame starts its check from the preset value
  a_r3_crc_preset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> crc == FCS_PRESET);
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned STUFF_RUN  = 5,
  parameter int unsigned IDLE_RUN   = 15,
  parameter int unsigned FCS_OCTETS = FCS_W / OCTET_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nrzi_en,
  input  logic               cd,
  input  logic               rxd,
  output logic               out_valid,
  output logic [OCTET_W-1:0] out_data,
  output logic               out_sof,
  output logic               frame_done,
  output logic               frame_err,
  output logic               abort_det,
  output logic               flag_det,
  output logic               line_idle
);
  localparam int unsigned LOOK = STUFF_RUN + 2;
  localparam int unsigned FW   = $clog2(LOOK + 1);
  localparam int unsigned HW   = $clog2(FCS_OCTETS + 1);
  localparam int unsigned AW   = $clog2(OCTET_W);

  logic bit_vld, bit_val;
  logic push, push_bit, flag_hit, abort_hit;
  logic [FCS_W-1:0] crc;

  rx_state_e            state;
  logic [LOOK-1:0]      look_sr;
  logic [FW-1:0]        look_fill;
  logic [OCTET_W-1:0]   asm_sr;
  logic [AW-1:0]        asm_cnt;
  logic [OCTET_W-1:0]   hold [FCS_OCTETS];
  logic [HW-1:0]        hold_cnt;
  logic                 any_bit;
  logic                 first_pend;

  logic                 in_open, commit, commit_bit, octet_end;
  logic [OCTET_W-1:0]   new_octet;

  hdlc_rx_line u_line (
    .clk(clk), .rst_n(rst_n), .nrzi_en(nrzi_en), .cd(cd), .rxd(rxd),
    .bit_vld(bit_vld), .bit_val(bit_val)
  );

  hdlc_rx_delin #(.STUFF_RUN(STUFF_RUN), .IDLE_RUN(IDLE_RUN)) u_delin (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .push(push), .push_bit(push_bit), .flag_hit(flag_hit),
    .abort_hit(abort_hit), .line_idle(line_idle)
  );

  assign in_open    = (state == ST_OPEN);
  assign commit     = push && in_open && (look_fill == FW'(LOOK));
  assign commit_bit = look_sr[0];
  assign octet_end  = commit && (asm_cnt == AW'(OCTET_W - 1));
  assign new_octet  = {commit_bit, asm_sr[OCTET_W-1:1]};

  hdlc_rx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(flag_hit || abort_hit),
    .upd(commit), .din(commit_bit), .crc(crc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      look_sr    <= '0;
      look_fill  <= '0;
      asm_sr     <= '0;
      asm_cnt    <= '0;
      hold_cnt   <= '0;
      any_bit    <= 1'b0;
      first_pend <= 1'b1;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sof    <= 1'b0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
      abort_det  <= 1'b0;
      flag_det   <= 1'b0;
      for (int i = 0; i < FCS_OCTETS; i++) hold[i] <= '0;
    end else begin
      out_valid  <= 1'b0;
      out_sof    <= 1'b0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
      abort_det  <= 1'b0;
      flag_det   <= flag_hit;
      if (flag_hit || abort_hit) begin
        if (flag_hit && in_open && any_bit) begin
          frame_done <= 1'b1;
          frame_err  <= (asm_cnt != '0) || (hold_cnt != HW'(FCS_OCTETS)) ||
                        (crc != FCS_RESIDUE);
        end
        if (abort_hit && in_open && any_bit) abort_det <= 1'b1;
        state      <= flag_hit ? ST_OPEN : ST_HUNT;
        look_fill  <= '0;
        asm_cnt    <= '0;
        hold_cnt   <= '0;
        any_bit    <= 1'b0;
        first_pend <= 1'b1;
      end else if (push && in_open) begin
        look_sr <= {push_bit, look_sr[LOOK-1:1]};
        if (look_fill != FW'(LOOK)) look_fill <= look_fill + 1'b1;
        if (commit) begin
          any_bit <= 1'b1;
          asm_sr  <= new_octet;
          asm_cnt <= asm_cnt + 1'b1;
        end
        if (octet_end) begin
          if (hold_cnt == HW'(FCS_OCTETS)) begin
            out_valid  <= 1'b1;
            out_data   <= hold[0];
            out_sof    <= first_pend;
            first_pend <= 1'b0;
            for (int i = 0; i < FCS_OCTETS - 1; i++) hold[i] <= hold[i+1];
            hold[FCS_OCTETS-1] <= new_octet;
          end else begin
            for (int i = 0; i < FCS_OCTETS; i++)
              if (HW'(i) == hold_cnt) hold[i] <= new_octet;
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
      end
    end
  end

  // R7: a carrier-low cycle produces no event in the next cycle
  a_r7_cd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cd |=> !(flag_det || out_valid || frame_done || abort_det));

  // R2: start-of-frame travels only with a delivered octet
  a_r2_sof_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  // R3: octet, frame end and abort events are mutually exclusive
  a_r3_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, frame_done, abort_det}));

  // R5: the error flag only qualifies a frame end
  a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> frame_done);
endmodule

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, nrzi_en = 1'b0, cd = 1'b0, rxd = 1'b1;
  logic out_valid, out_sof, frame_done, frame_err, abort_det, flag_det, line_idle;
  logic [7:0] out_data;

  hdlc_rx_deframer u_dut (
    .clk(clk), .rst_n(rst_n), .nrzi_en(nrzi_en), .cd(cd), .rxd(rxd),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .frame_done(frame_done), .frame_err(frame_err), .abort_det(abort_det),
    .flag_det(flag_det), .line_idle(line_idle)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] got_d[$];
  bit got_s[$];
  bit got_e[$];
  int n_abort = 0, n_flag = 0;
  logic last_lvl = 1'b1;
  int st_ones = 0;
  bit gaps_on = 1'b0;
  int unsigned seed_init;

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin got_d.push_back(out_data); got_s.push_back(out_sof); end
    if (frame_done) got_e.push_back(frame_err);
    if (abort_det) n_abort++;
    if (flag_det) n_flag++;
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  task automatic drive(bit b, bit c);
    @(negedge clk);
    cd = c;
    if (!c) rxd = 1'($urandom & 1);
    else begin
      rxd = nrzi_en ? (b ? last_lvl : ~last_lvl) : b;
      last_lvl = rxd;
    end
  endtask

  task automatic tx_bit(bit b);
    if (gaps_on && ($urandom % 6 == 0)) drive(1'b0, 1'b0);
    drive(b, 1'b1);
  endtask

  task automatic tx_flag();
    tx_bit(0);
    for (int i = 0; i < 6; i++) tx_bit(1);
    tx_bit(0);
    st_ones = 0;
  endtask

  task automatic tx_data_bit(bit b);
    tx_bit(b);
    if (b) begin
      st_ones++;
      if (st_ones == 5) begin tx_bit(0); st_ones = 0; end
    end else st_ones = 0;
  endtask

  task automatic tx_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) tx_data_bit(v[i]);
  endtask

  function automatic logic [15:0] crc_of(logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[k])
      for (int i = 0; i < 8; i++) begin
        bit fb = c[0] ^ q[k][i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return c;
  endfunction

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0);
  endtask

  task automatic clear_mon();
    got_d.delete(); got_s.delete(); got_e.delete();
    n_abort = 0; n_flag = 0;
  endtask

  task automatic run_frame(string tag, logic [7:0] d[$], bit corrupt, int extra, bit exp_err);
    logic [15:0] fcs = ~crc_of(d);
    if (corrupt) fcs = fcs ^ 16'h0100;
    clear_mon();
    tx_flag();
    foreach (d[k]) tx_byte(d[k]);
    tx_byte(fcs[7:0]);
    tx_byte(fcs[15:8]);
    for (int i = 0; i < extra; i++) tx_data_bit(i[0]);
    tx_flag();
    quiet(3);
    check({tag, " R1 flag pulses"}, n_flag, 2);
    check({tag, " frame_done count"}, got_e.size(), 1);
    if (got_e.size() == 1) check({tag, " frame_err"}, got_e[0], exp_err);
    if (!exp_err) begin
      check({tag, " R3 octets delivered"}, got_d.size(), d.size());
      if (got_d.size() == d.size())
        foreach (d[k]) begin
          check({tag, " R2 octet"}, got_d[k], d[k]);
          check({tag, " R2 sof"}, got_s[k], (k == 0));
        end
    end
  endtask

  initial begin
    logic [7:0] d[$];
    seed_init = $urandom(32'h5EED1);
    repeat (4) @(negedge clk);
    check("R10 out_valid", out_valid, 0);
    check("R10 frame_done", frame_done, 0);
    check("R10 flag_det", flag_det, 0);
    check("R10 line_idle", line_idle, 0);
    check("R10 abort_det", abort_det, 0);
    rst_n = 1'b1;
    quiet(2);

    // R11: adjacent flags, no content
    clear_mon();
    tx_flag(); tx_flag(); tx_flag(); quiet(2);
    check("R11 no frame_done", got_e.size(), 0);
    check("R11 R1 flags", n_flag, 3);

    // good frames, directed stuffing-heavy payload
    d = '{8'hFF, 8'h7E, 8'h1F, 8'hF8};
    run_frame("R3 stuffed", d, 0, 0, 0);
    nrzi_en = 1'b1;
    run_frame("R6 nrzi stuffed", d, 0, 0, 0);
    nrzi_en = 1'b0;

    // R4: corrupted FCS
    d = '{8'h12, 8'h34, 8'h56};
    run_frame("R4 bad fcs", d, 1, 0, 1);

    // R5: non-octet tail and short frame
    run_frame("R5 non-octet", d, 0, 3, 1);
    clear_mon();
    tx_flag(); tx_byte(8'hA5); tx_flag(); quiet(3);
    check("R5 short done", got_e.size(), 1);
    if (got_e.size() == 1) check("R5 short err", got_e[0], 1);
    check("R5 short no data", got_d.size(), 0);

    // R8: abort after content, then recovery
    clear_mon();
    tx_flag(); tx_byte(8'h81); tx_byte(8'h42); tx_byte(8'h24);
    for (int i = 0; i < 7; i++) tx_bit(1);
    tx_bit(0); quiet(3);
    check("R8 abort pulse", n_abort, 1);
    check("R8 no frame_done", got_e.size(), 0);
    d = '{8'h99, 8'h00};
    run_frame("R8 recovery", d, 0, 0, 0);
    clear_mon();
    tx_flag();
    for (int i = 0; i < 7; i++) tx_bit(1);
    tx_bit(0); quiet(3);
    check("R8 ones after flag", n_abort, 0);

    // R9: idle threshold probed through carrier-low pauses (also R7)
    for (int i = 0; i < 14; i++) drive(1'b1, 1'b1);
    drive(1'b0, 1'b0);
    check("R9 idle after 14", line_idle, 0);
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b0);
    check("R9 R7 idle after 15", line_idle, 1);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    check("R9 idle cleared", line_idle, 0);

    // R7: frame with carrier gaps
    gaps_on = 1'b1;
    d = '{8'h3C, 8'hFE, 8'h01, 8'h7F, 8'hBD};
    run_frame("R7 gaps", d, 0, 0, 0);

    // random frames, both codings, with gaps
    for (int f = 0; f < 40; f++) begin
      int len = 1 + ($urandom % 10);
      d.delete();
      for (int k = 0; k < len; k++) d.push_back(8'($urandom));
      nrzi_en = 1'($urandom & 1);
      gaps_on = 1'($urandom & 1);
      run_frame(nrzi_en ? "R6 random" : "R2 random", d, 0, 0, 0);
    end
    summary();
  end
endmodule